// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block is the digital sequencer in front of a shared analog-to-digital converter. It has up to four sample/hold channels. It decides which channels acquire, which analog input each channel looks at, and the order in which the held values go to the converter. Software sets a channel count and a sampling mode. A sample-start pulse opens a sequence and a trigger pulse ends each acquisition. The converter is driven through a request/done handshake. Every finished conversion comes back as a one-cycle result strobe tagged with its channel and input number.

Per sequence, the input selection can come from two fixed input sets, "A" and "B". The sequencer can alternate between the two sets on successive sequences. In set A, channel 0 can also sweep through the inputs marked in a 16-bit scan mask. After a programmed number of sequences the block raises an interrupt pulse. At that point the scan sweep restarts from the lowest marked input.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `chan_cnt_i` selects the channels used: 2'b00 uses channel 0 only, 2'b01 uses channels 0 and 1, and 2'b10 or 2'b11 uses channels 0 to 3. Within a sequence, conversions and results always run in ascending channel order, and `conv_ch_o`/`res_ch_o` carry the channel index.
- R2: With `simul_i` low, each channel acquires on its own. While channel k acquires, `samp_o` equals 1<<k. Each channel needs its own `trig_i` pulse, and the next channel starts acquiring automatically after the previous conversion completes.
- R3: With `simul_i` high, all selected channels acquire together. `samp_o` has one bit set per selected channel. A single `trig_i` ends the acquisition, and all selected channels are then converted one after another with no further trigger.
- R4: When enabled and idle, a `start_i` pulse begins acquisition on the next cycle. A `trig_i` pulse outside an acquisition is ignored: it raises neither `conv_req_o` nor `samp_o`.
- R5: `conv_req_o` goes high on the cycle after the trigger. It stays high, with `conv_ch_o` stable, until `conv_done_i` is seen. Only one conversion is outstanding at a time.
- R6: The cycle after `conv_done_i` is accepted, `res_valid_o` is high for exactly that cycle. It carries the converted channel on `res_ch_o` and that channel's 4-bit input number on `res_input_o`.
- R7: With `alt_i` low, every channel uses its set-A code from `mux_a_i` (channel k in bits [4k+3:4k]). With `alt_i` high, sequences alternate between set A and set B (`mux_b_i`, same layout), starting with A.
- R8: With `scan_en_i` high, a set-A sequence puts channel 0 on input n, where bit n of `scan_mask_i` is set. Successive set-A sequences step upward through the set bits and wrap to the lowest set bit after the highest. Set-B sequences do not move the sweep. With an empty mask, channel 0 uses its `mux_a_i` code.
- R9: `irq_o` pulses together with the last result of every (`seq_per_irq_i`+1)-th sequence. After that pulse, the scan sweep restarts at the lowest set mask bit.
- R10: While `en_i` is low, the block is idle with no strobes. When it is re-enabled, the next sequence uses set A, the sequence count starts from zero and the scan sweep starts from the lowest set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| chan_cnt_i | input | 2 | Channel count select |
| simul_i | input | 1 | Simultaneous sampling mode |
| alt_i | input | 1 | Alternate A/B input sets per sequence |
| scan_en_i | input | 1 | Channel 0 scan enable |
| scan_mask_i | input | 16 | Inputs included in the channel 0 scan |
| seq_per_irq_i | input | 4 | Sequences per interrupt, minus one |
| mux_a_i | input | 16 | Set-A input code per channel |
| mux_b_i | input | 16 | Set-B input code per channel |
| start_i | input | 1 | Sample-start pulse |
| trig_i | input | 1 | Acquisition-end / convert trigger pulse |
| conv_done_i | input | 1 | Converter finished current request |
| samp_o | output | 4 | Per-channel sample/hold acquire strobe |
| sel_o | output | 16 | Per-channel input-select code |
| conv_req_o | output | 1 | Conversion request |
| conv_ch_o | output | 2 | Channel being converted |
| res_valid_o | output | 1 | Result strobe |
| res_ch_o | output | 2 | Channel of the result |
| res_input_o | output | 4 | Input number of the result |
| irq_o | output | 1 | Interrupt pulse |

## Verification
If the channel index goes wrong, `res_ch_o` shows it on the very first result of the sequence. It also shows in the acquire strobe pattern, which the bench compares at each acquisition. A wrong A/B phase bit or scan sweep register changes no timing. It does change `res_input_o`, so every result is compared against an independently tracked input number, and an error shows within one sequence of its cause. A sequence counter that is off by one shows as `irq_o` on the wrong result. The scoreboard checks that flag on every result, so the error appears at the first interrupt boundary.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seq_st_e;
endpackage

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
  parameter int NIN = 16,
  parameter int IW  = 4
) (
  input  logic [NIN-1:0] mask_i,
  input  logic [NIN-1:0] used_i,
  output logic [IW-1:0]  pick_o,
  output logic           wrap_o,
  output logic           any_o
);
  logic [NIN-1:0] rem;
  logic [NIN-1:0] src;

  assign rem    = mask_i & ~used_i;
  assign wrap_o = (rem == '0);
  assign src    = wrap_o ? mask_i : rem;
  assign any_o  = |mask_i;

  // lowest set bit wins: scan from top so the last hit is the lowest
  always_comb begin
    pick_o = '0;
    for (int i = NIN - 1; i >= 0; i--) begin
      if (src[i]) pick_o = IW'(i);
    end
  end
endmodule

// File: rtl/adc_irq_cnt.sv
module adc_irq_cnt #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [CW-1:0] limit_i,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int IW  = 4,
  parameter int CW  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [1:0]            chan_cnt_i,
  input  logic                  simul_i,
  input  logic                  alt_i,
  input  logic                  scan_en_i,
  input  logic [(1<<IW)-1:0]    scan_mask_i,
  input  logic [CW-1:0]         seq_per_irq_i,
  input  logic [NCH*IW-1:0]     mux_a_i,
  input  logic [NCH*IW-1:0]     mux_b_i,
  input  logic                  start_i,
  input  logic                  trig_i,
  input  logic                  conv_done_i,
  output logic [NCH-1:0]        samp_o,
  output logic [NCH*IW-1:0]     sel_o,
  output logic                  conv_req_o,
  output logic [$clog2(NCH)-1:0] conv_ch_o,
  output logic                  res_valid_o,
  output logic [$clog2(NCH)-1:0] res_ch_o,
  output logic [IW-1:0]         res_input_o,
  output logic                  irq_o
);
  localparam int NIN = 1 << IW;
  localparam int CHW = $clog2(NCH);

  seq_st_e          st_q;
  logic [CHW-1:0]   ch_q;
  logic [CHW-1:0]   last_ch;
  logic [NCH-1:0]   act_mask;
  logic             use_b_q;
  logic [NIN-1:0]   used_q;
  logic [IW-1:0]    pick;
  logic             pick_wrap;
  logic             mask_any;
  logic             scan_act;
  logic             done_ev;
  logic             seq_end;
  logic             irq_wrap;
  logic [IW-1:0]    sel [NCH];

  always_comb begin
    unique case (chan_cnt_i)
      2'b00:   last_ch = '0;
      2'b01:   last_ch = CHW'(1);
      default: last_ch = CHW'(NCH - 1);
    endcase
  end

  adc_scan_pick #(.NIN(NIN), .IW(IW)) u_pick (
    .mask_i (scan_mask_i),
    .used_i (used_q),
    .pick_o (pick),
    .wrap_o (pick_wrap),
    .any_o  (mask_any)
  );

  assign scan_act = scan_en_i && !use_b_q && mask_any;
  assign done_ev  = (st_q == ST_CONV) && conv_done_i;
  assign seq_end  = done_ev && (ch_q == last_ch);

  adc_irq_cnt #(.CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!en_i),
    .step_i  (seq_end),
    .limit_i (seq_per_irq_i),
    .wrap_o  (irq_wrap)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    if (k == 0) begin : g_ch0
      assign sel[k] = use_b_q  ? mux_b_i[k*IW +: IW] :
                      scan_act ? pick : mux_a_i[k*IW +: IW];
    end else begin : g_chn
      assign sel[k] = use_b_q ? mux_b_i[k*IW +: IW] : mux_a_i[k*IW +: IW];
    end
    assign act_mask[k] = (CHW'(k) <= last_ch);
    assign sel_o[k*IW +: IW] = sel[k];
  end

  always_comb begin
    samp_o = '0;
    if (st_q == ST_ACQ) samp_o = simul_i ? act_mask : (NCH'(1) << ch_q);
  end

  assign conv_req_o = (st_q == ST_CONV);
  assign conv_ch_o  = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ch_q    <= '0;
      use_b_q <= 1'b0;
    end else if (!en_i) begin
      st_q    <= ST_IDLE;
      ch_q    <= '0;
      use_b_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q <= ST_ACQ;
          ch_q <= '0;
        end
        ST_ACQ: if (trig_i) st_q <= ST_CONV;
        ST_CONV: if (conv_done_i) begin
          if (ch_q == last_ch) begin
            st_q    <= ST_IDLE;
            ch_q    <= '0;
            use_b_q <= alt_i && !use_b_q;
          end else begin
            ch_q <= ch_q + 1'b1;
            // simultaneous: all held already, go straight to next conversion
            st_q <= simul_i ? ST_CONV : ST_ACQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 used_q <= '0;
    else if (!en_i || irq_wrap)  used_q <= '0;
    else if (done_ev && ch_q == '0 && scan_act)
      used_q <= (pick_wrap ? '0 : used_q) | (NIN'(1) << pick);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_ch_o    <= '0;
      res_input_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      res_valid_o <= done_ev && en_i;
      irq_o       <= irq_wrap && en_i;
      if (done_ev) begin
        res_ch_o    <= ch_q;
        res_input_o <= sel[ch_q];
      end
    end
  end

  // R5: request held with stable channel until done
  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && !conv_done_i && en_i) |=> (conv_req_o && $stable(conv_ch_o)));

  // R6: each result follows an accepted handshake
  a_r6_res_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(conv_req_o && conv_done_i));

  // R9: interrupt only with a result
  a_r9_irq_with_res: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> res_valid_o);

  // R10: disable clears strobes and A/B phase
  a_r10_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!conv_req_o && samp_o == '0 && !use_b_q));

  // R8: scanned input is always a member of the mask
  a_r8_pick_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_act |-> scan_mask_i[pick]);

  // R2: sequential mode acquires one channel at a time
  a_r2_one_acq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !simul_i |-> $onehot0(samp_o));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  typedef struct {
    logic [1:0] ch;
    logic [3:0] inp;
    logic       irq;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  chan_cnt = 2'b00;
  logic        simul = 1'b0;
  logic        alt = 1'b0;
  logic        scan_en = 1'b0;
  logic [15:0] scan_mask = '0;
  logic [3:0]  spi = '0;
  logic [15:0] mux_a = {4'd11, 4'd10, 4'd9, 4'd6};
  logic [15:0] mux_b = {4'd15, 4'd14, 4'd13, 4'd12};
  logic        start = 1'b0;
  logic        trig = 1'b0;
  logic        done = 1'b0;
  logic [3:0]  samp;
  logic [15:0] sel;
  logic        conv_req;
  logic [1:0]  conv_ch;
  logic        res_valid;
  logic [1:0]  res_ch;
  logic [3:0]  res_input;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  exp_t q[$];

  // bench-side model state
  logic        m_b = 1'b0;
  logic [15:0] m_used = '0;
  int          m_cnt = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .chan_cnt_i(chan_cnt),
    .simul_i(simul), .alt_i(alt), .scan_en_i(scan_en), .scan_mask_i(scan_mask),
    .seq_per_irq_i(spi), .mux_a_i(mux_a), .mux_b_i(mux_b), .start_i(start),
    .trig_i(trig), .conv_done_i(done), .samp_o(samp), .sel_o(sel),
    .conv_req_o(conv_req), .conv_ch_o(conv_ch), .res_valid_o(res_valid),
    .res_ch_o(res_ch), .res_input_o(res_input), .irq_o(irq)
  );

  // converter model: done two cycles into each request
  int cdel = 0;
  always @(negedge clk) begin
    if (done) begin
      done <= 1'b0;
      cdel <= 0;
    end else if (conv_req) begin
      if (cdel == 1) done <= 1'b1;
      cdel <= cdel + 1;
    end else cdel <= 0;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected <=20000", cyc);
      summary();
    end
  end

  // monitor
  always @(negedge clk) begin
    if (res_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R6: unexpected result ch=%0d in=%0d, expected none", res_ch, res_input);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (res_ch !== e.ch || res_input !== e.inp || irq !== e.irq) begin
          fails++;
          $display("FAIL %s: actual ch=%0d in=%0d irq=%0b expected ch=%0d in=%0d irq=%0b",
                   e.tag, res_ch, res_input, irq, e.ch, e.inp, e.irq);
        end
      end
    end
  end

  function automatic int nch_of(logic [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [3:0] scan_next();
    logic [15:0] rem;
    rem = scan_mask & ~m_used;
    if (rem == '0) begin
      m_used = '0;
      rem = scan_mask;
    end
    for (int i = 15; i >= 0; i--) if (rem[i]) scan_next = 4'(i);
    m_used[scan_next] = 1'b1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_samp();
    do @(negedge clk); while (samp == '0);
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic run_seq(string tag);
    int n;
    n = nch_of(chan_cnt);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.ch  = 2'(k);
      e.tag = tag;
      if (m_b)                                e.inp = mux_b[k*4 +: 4];
      else if (k == 0 && scan_en && scan_mask != '0) e.inp = scan_next();
      else                                    e.inp = mux_a[k*4 +: 4];
      e.irq = (k == n - 1) && (m_cnt == int'(spi));
      q.push_back(e);
    end
    if (m_cnt == int'(spi)) begin
      m_cnt = 0;
      m_used = '0;
    end else m_cnt++;
    m_b = alt && !m_b;

    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (simul && n > 1) begin
      wait_samp();
      chk(samp == 4'((1 << n) - 1), "R3 samp all", samp, (1 << n) - 1);
      pulse_trig();
    end else begin
      for (int k = 0; k < n; k++) begin
        wait_samp();
        chk(samp == 4'(1 << k), "R2 samp one", samp, 1 << k);
        pulse_trig();
      end
    end
    do @(negedge clk); while (q.size() != 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(samp == 0 && !conv_req && !res_valid && !irq, "R4 reset idle",
        {samp, conv_req, res_valid, irq}, 0);
    en = 1'b1;
    @(negedge clk);

    // R4: trigger while idle is ignored
    pulse_trig();
    repeat (3) begin
      chk(!conv_req && samp == 0, "R4 trig ignored", {samp, conv_req}, 0);
      @(negedge clk);
    end

    // R1 R6: single channel, plain set A
    run_seq("R1 one ch");

    // R2 R9: two channels sequential, irq every 2nd sequence
    chan_cnt = 2'b01; spi = 4'd1;
    run_seq("R2 seq 2ch");
    run_seq("R9 irq 2nd");

    // R3 R1: four channels simultaneous (code 11)
    chan_cnt = 2'b11; simul = 1'b1; spi = 4'd0;
    run_seq("R3 simul 4ch");
    chan_cnt = 2'b10; simul = 1'b0;
    run_seq("R1 seq 4ch");

    // R7: alternation A,B,A
    chan_cnt = 2'b01; simul = 1'b1; alt = 1'b1;
    run_seq("R7 alt A");
    run_seq("R7 alt B");
    run_seq("R7 alt A2");
    // leave phase on A
    run_seq("R7 alt B2");
    alt = 1'b0;

    // R8 R9: scan over bits 0,2,9,11; 3 per irq, then restart
    chan_cnt = 2'b00; simul = 1'b0; scan_en = 1'b1; scan_mask = 16'h0A05; spi = 4'd2;
    for (int i = 0; i < 3; i++) run_seq("R8 scan");
    for (int i = 0; i < 3; i++) run_seq("R9 scan restart");
    spi = 4'd5;
    for (int i = 0; i < 6; i++) run_seq("R8 scan wrap");

    // R8: empty mask uses set-A code
    scan_mask = '0; spi = 4'd0;
    run_seq("R8 empty mask");

    // R8 R7: scan with alternation, B does not advance sweep
    scan_mask = 16'h8030; alt = 1'b1; spi = 4'd3;
    for (int i = 0; i < 4; i++) run_seq("R8 scan alt");

    // R10: disable returns to set A and restarts count/sweep
    spi = 4'd1;
    run_seq("R10 pre");
    en = 1'b0;
    m_b = 1'b0; m_used = '0; m_cnt = 0;
    repeat (2) @(negedge clk);
    chk(!conv_req && samp == 0, "R10 disabled idle", {samp, conv_req}, 0);
    en = 1'b1;
    run_seq("R10 after en");
    run_seq("R10 after en2");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule